// File: doc/BRIEF.md
# First-Come-First-Served Ticket Arbiter

This block shares one resource among `N_REQ` requesters and hands it out strictly in the order the requests arrived. It works like a take-a-number counter. A dispenser counter gives each newly raised request a number, and each requester keeps its own number while it waits. A serving counter holds the number whose turn has come. When the resource is free, the requester whose number equals the serving value receives a registered one-hot grant.

A requester raises its level request and holds it through the whole time it is served. Lowering the request frees the resource and advances the serving counter in the same clock edge. Requests that rise in the same cycle are numbered by ascending requester index. Both counters are `$clog2(N_REQ)+1` bits wide and wrap, so numbering continues indefinitely. At most `N_REQ` numbers are outstanding at any time.

Top module: `fcfs_ticket_arb`

## Requirements
- R1: A synchronous active-high reset clears all grants, both counters, the lock and all stored numbers; a request raised after reset, even one that follows a reset in mid-service, is granted with the normal latency.
- R2: A request first seen high at clock edge k receives its number at edge k; when the resource is free and that number is the serving value, the grant rises at edge k+1.
- R3: `gnt` is one-hot or zero, and the resource is busy exactly while a grant is high.
- R4: A grant stays high for as long as its requester keeps its request high, whatever other requests arrive.
- R5: When the owner lowers its request, its grant falls at the next edge and the serving value advances by one; no grant is high at that edge, and the next grant can rise no earlier than the edge after.
- R6: A request that rises in an earlier cycle is granted before one that rises later, regardless of requester index.
- R7: Requests that rise in the same cycle are granted in ascending index order (bit 0 first).
- R8: The counters wrap modulo 2^(`$clog2(N_REQ)+1`), and arrival order is preserved across more than one wrap.
- R9: A requester that raises a new request after its release is queued behind every request already waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N_REQ | Level request, one bit per requester (bit i is requester i) |
| gnt | output | N_REQ | Registered one-hot grant, one bit per requester |

## Verification
The bench changes inputs on falling edges and reads `gnt` on later falling edges. A request set before edge k shows its grant at the second falling edge after it is driven. After a release, the grant is low at the first falling edge, and any waiting grant appears at the second. Each scenario task counts the falling edges it waits for a grant and compares that count with the latency these rules predict: two for a fresh request into an idle arbiter, one after a release gap. The grant pattern is checked against the arrival order the bench itself created. Holds and release gaps are checked on the exact falling edge where the rules place them.

// File: rtl/fcfs_pkg.sv
package fcfs_pkg;
    // Counter width: one bit more than needed to index requesters, so
    // N outstanding numbers never alias after wrap.
    function automatic int tkt_bits(input int n);
        return $clog2(n) + 1;
    endfunction
endpackage

// File: rtl/fcfs_ticket_issue.sv
module fcfs_ticket_issue #(
    parameter int N_REQ = 4,
    parameter int TW    = 3
) (
    input  logic [N_REQ-1:0]         rise,
    input  logic [TW-1:0]            disp_q,
    output logic [N_REQ-1:0][TW-1:0] tkt_new,
    output logic [TW-1:0]            disp_d
);
    logic [TW-1:0] run;

    // Same-cycle arrivals take consecutive numbers, lowest index first.
    always_comb begin
        run = disp_q;
        for (int i = 0; i < N_REQ; i++) begin
            tkt_new[i] = run;
            if (rise[i]) begin
                run = run + TW'(1);
            end
        end
        disp_d = run;
    end
endmodule

// File: rtl/fcfs_serve_match.sv
module fcfs_serve_match #(
    parameter int N_REQ = 4,
    parameter int TW    = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_REQ-1:0]         pend,
    input  logic [N_REQ-1:0][TW-1:0] tkt,
    input  logic [TW-1:0]            serve,
    output logic [N_REQ-1:0]         pick
);
    logic [N_REQ-1:0] hit;
    logic             found;

    for (genvar g = 0; g < N_REQ; g++) begin : g_cmp
        assign hit[g] = pend[g] && (tkt[g] == serve);
    end

    always_comb begin
        found = 1'b0;
        for (int i = 0; i < N_REQ; i++) begin
            pick[i] = hit[i] && !found;
            found   = found | hit[i];
        end
    end

    // R6: pending numbers are unique, so at most one waiter matches.
    a_r6_unique_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));
endmodule

// File: rtl/fcfs_ticket_arb.sv
module fcfs_ticket_arb #(
    parameter int N_REQ = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_REQ-1:0] req,
    output logic [N_REQ-1:0] gnt
);
    localparam int TW = fcfs_pkg::tkt_bits(N_REQ);

    typedef struct packed {
        logic [TW-1:0]            disp;
        logic [TW-1:0]            serve;
        logic                     busy;
        logic [N_REQ-1:0]         req_seen;
        logic [N_REQ-1:0]         pend;
        logic [N_REQ-1:0][TW-1:0] tkt;
        logic [N_REQ-1:0]         gnt;
    } arb_st_t;

    arb_st_t                  st_q, st_d;
    logic [N_REQ-1:0]         rise;
    logic [N_REQ-1:0]         rel;
    logic [N_REQ-1:0]         pick;
    logic [N_REQ-1:0][TW-1:0] tkt_new;
    logic [TW-1:0]            disp_nx;

    assign rise = req & ~st_q.req_seen;
    assign rel  = st_q.gnt & ~req;

    fcfs_ticket_issue #(.N_REQ(N_REQ), .TW(TW)) issue_i (
        .rise    (rise),
        .disp_q  (st_q.disp),
        .tkt_new (tkt_new),
        .disp_d  (disp_nx)
    );

    fcfs_serve_match #(.N_REQ(N_REQ), .TW(TW)) match_i (
        .clk   (clk),
        .rst   (rst),
        .pend  (st_q.pend),
        .tkt   (st_q.tkt),
        .serve (st_q.serve),
        .pick  (pick)
    );

    always_comb begin
        st_d          = st_q;
        st_d.req_seen = req;
        st_d.disp     = disp_nx;
        for (int i = 0; i < N_REQ; i++) begin
            if (rise[i]) begin
                st_d.tkt[i]  = tkt_new[i];
                st_d.pend[i] = 1'b1;
            end
        end
        if (st_q.busy) begin
            if (|rel) begin
                // Release: advance the turn and free the lock together.
                st_d.serve = st_q.serve + TW'(1);
                st_d.busy  = 1'b0;
                st_d.gnt   = '0;
                st_d.pend  = st_d.pend & ~st_q.gnt;
            end
        end else if (|pick) begin
            st_d.gnt  = pick;
            st_d.busy = 1'b1;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign gnt = st_q.gnt;

    // R1: reset leaves no grant behind.
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (st_q.gnt == '0));

    // R3: one owner at most, and the lock mirrors the grant.
    a_r3_onehot_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(st_q.gnt));
    a_r3_busy_tracks: assert property (@(posedge clk) disable iff (rst)
        st_q.busy == (|st_q.gnt));

    // R4: an owner keeps the grant while it holds its request.
    a_r4_grant_held: assert property (@(posedge clk) disable iff (rst)
        ((st_q.gnt & req) != '0) |=> (st_q.gnt == $past(st_q.gnt)));

    // R5: release gives a one-cycle gap and advances the turn.
    a_r5_release_gap: assert property (@(posedge clk) disable iff (rst)
        ((st_q.gnt & ~req) != '0) |=> (st_q.gnt == '0));
    a_r5_serve_step: assert property (@(posedge clk) disable iff (rst)
        ((st_q.gnt & ~req) != '0) |=> (st_q.serve == $past(st_q.serve) + TW'(1)));

    // R2: a grant only rises for a requester holding a number.
    for (genvar g = 0; g < N_REQ; g++) begin : g_chk
        a_r2_grant_needs_ticket: assert property (@(posedge clk) disable iff (rst)
            $rose(st_q.gnt[g]) |-> st_q.pend[g]);
    end
endmodule

// File: tb/fcfs_ticket_arb_tb.sv
module fcfs_ticket_arb_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] req;
    logic [N-1:0] gnt;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           done  = 1'b0;

    always #10 clk = ~clk;

    fcfs_ticket_arb #(.N_REQ(N)) dut_i (
        .clk (clk),
        .rst (rst),
        .req (req),
        .gnt (gnt)
    );

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    task automatic chk_vec(string rq, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: gnt actual %b expected %b", rq, act, exp);
        end
    endtask

    task automatic chk_int(string rq, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: wait actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // Waits for the grant, checks owner and latency, hold, then release gap.
    task automatic drain_one(int idx, int exp_wait, string rq);
        int w = 0;
        while (gnt == '0 && w < 12) begin
            @(negedge clk);
            w++;
        end
        chk_vec(rq, gnt, N'(1) << idx);
        if (exp_wait >= 0) chk_int({rq, " latency"}, w, exp_wait);
        @(negedge clk);
        chk_vec("R4 hold", gnt, N'(1) << idx);
        req[idx] = 1'b0;
        @(negedge clk);
        chk_vec("R5 release gap", gnt, '0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        req = '1;
        repeat (3) begin
            @(negedge clk);
            chk_vec("R1 reset gnt", gnt, '0);
        end
        req = '0;
        rst = 1'b0;
        @(negedge clk);
        chk_vec("R1 idle after reset", gnt, '0);
    endtask

    task automatic t_single();
        req[2] = 1'b1;
        @(negedge clk);
        chk_vec("R2 not yet", gnt, '0);
        @(negedge clk);
        chk_vec("R2 first grant", gnt, 4'b0100);
        req[1] = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk_vec("R4 hold with waiter", gnt, 4'b0100);
        end
        req[2] = 1'b0;
        @(negedge clk);
        chk_vec("R5 gap", gnt, '0);
        drain_one(1, 1, "R5 next after gap");
    endtask

    task automatic t_mid_reset();
        req[3] = 1'b1;
        drain_one(3, 2, "R1 pre-reset grant");
        req[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk_vec("R1 granted before reset", gnt, 4'b0001);
        rst = 1'b1;
        req = '0;
        @(negedge clk);
        chk_vec("R1 mid reset", gnt, '0);
        rst = 1'b0;
        req[1] = 1'b1;
        drain_one(1, 2, "R1 counters cleared");
    endtask

    task automatic t_same();
        req = '1;
        drain_one(0, 2, "R7 idx0");
        drain_one(1, 1, "R7 idx1");
        drain_one(2, 1, "R7 idx2");
        drain_one(3, 1, "R7 idx3");
    endtask

    task automatic t_order();
        req[3] = 1'b1;
        @(negedge clk);
        req[0] = 1'b1;
        @(negedge clk);
        req[1] = 1'b1;
        drain_one(3, 0, "R6 first arrival");
        drain_one(0, 1, "R6 second arrival");
        drain_one(1, 1, "R6 third arrival");
    endtask

    task automatic t_requeue();
        req = 4'b0011;
        @(negedge clk);
        req[3] = 1'b1;
        drain_one(0, 1, "R9 first");
        req[0] = 1'b1;
        drain_one(1, 1, "R9 waiter1");
        drain_one(3, 1, "R9 waiter3");
        drain_one(0, 1, "R9 requeued last");
    endtask

    task automatic t_wrap();
        for (int r = 0; r < 5; r++) begin
            req = '1;
            drain_one(0, 2, "R8 wrap idx0");
            for (int i = 1; i < N; i++) drain_one(i, 1, "R8 wrap asc");
        end
        for (int r = 0; r < 3; r++) begin
            for (int i = N - 1; i >= 0; i--) begin
                req[i] = 1'b1;
                if (i > 0) @(negedge clk);
            end
            drain_one(N - 1, 0, "R8 wrap desc first");
            for (int i = N - 2; i >= 0; i--) drain_one(i, 1, "R8 wrap desc");
        end
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        req = '0;
        @(negedge clk);
        t_reset();
        t_single();
        t_mid_reset();
        t_same();
        t_order();
        t_requeue();
        t_wrap();
        repeat (2) @(negedge clk);
        chk_vec("R3 idle at end", gnt, '0);
        summary();
        $finish;
    end
endmodule